// File: doc/BRIEF.md
# Shared-Bus Register Transfer Unit

The unit holds three data registers that all hang off one common bus. On each cycle a two-bit source selector puts exactly one value on that bus: the contents of one of the three registers, or a word from an external data input. A three-bit load vector, one bit per register, names the registers that capture the bus value at the next rising clock edge. Any mix of registers may capture in the same cycle, including none and all three. The source choice is the only routing control, so one value moves per cycle.

The bus is modelled as an AND-OR selector driven by a one-hot drive vector. This behaves like a node that tri-state buffers drive, without using any real tri-state logic. Because only one value moves per edge, any exchange between two registers goes through the third register over three cycles.

Top module: `bus_xfer_unit`

## Requirements
- R1: With the source selector at 0, 1 or 2, `busOut` shows the present contents of register 0, 1 or 2 in the same cycle, with no clock edge in between.
- R2: With the source selector at 3, `busOut` shows `extData` in the same cycle.
- R3: At a rising edge, every register whose load bit is 1 takes the value the bus held just before that edge. All such registers get the same value, whatever their number.
- R4: A register whose load bit is 0 keeps its value across the edge, also when it is the selected source.
- R5: A register that is both the selected source and a loaded destination keeps its value unchanged.
- R6: While `rstN` is low, all three registers read zero, with no clock edge needed.
- R7: Three cycles of transfers (R2 from R0, then R0 from R1, then R1 from R2) exchange the contents of registers 0 and 1.
- R8: In `regFlat`, register k sits at bits [k*DATA_W +: DATA_W]. Bit k of `loadEn` belongs to register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Bus source: 0..2 register, 3 external input |
| loadEn | input | 3 | Per-register capture enable |
| extData | input | DATA_W | External word offered to the bus |
| busOut | output | DATA_W | Current bus value |
| regFlat | output | 3*DATA_W | All register contents, register k at slice k |

## Verification
The bench sweeps all four source codes against all eight load patterns several times, and compares against a register model that it keeps itself. Cases where the source is also a destination expose a design that samples the bus after the update or reloads stale data. Cases with load bit 0 on the selected source catch a design that ties the load to the selection. Patterns with no loads and with all registers loaded catch a load gate that is wrong for a single bit or mixes up the slice order. A swap through the spare register, and a reset asserted between edges, catch a wrong transfer order and a reset that waits for the clock.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
  localparam int NUM_REGS = 3;
  localparam int SRC_CNT  = NUM_REGS + 1;
  localparam int SEL_W    = $clog2(SRC_CNT);
  localparam int EXT_IDX  = NUM_REGS;

  typedef struct packed {
    logic [SRC_CNT-1:0]  drive;    // one-hot bus driver enables
    logic [NUM_REGS-1:0] capture;  // per-register capture strobes
  } xfer_strobe_t;
endpackage

// File: rtl/bus_xfer_ctrl.sv
module bus_xfer_ctrl
  import bus_xfer_pkg::*;
(
  input  logic [SEL_W-1:0]    srcSel,
  input  logic [NUM_REGS-1:0] loadEn,
  output xfer_strobe_t        strobe
);
  logic [SRC_CNT-1:0] driveDec;

  // Decode the source code into one driver enable; codes beyond the
  // register range all map onto the external input.
  always_comb begin
    driveDec = '0;
    if (int'(srcSel) >= EXT_IDX) begin
      driveDec[EXT_IDX] = 1'b1;
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (int'(srcSel) == k) driveDec[k] = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.drive   = driveDec;
    strobe.capture = loadEn;
  end
endmodule

// File: rtl/bus_xfer_dp.sv
module bus_xfer_dp
  import bus_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  xfer_strobe_t               strobe,
  input  logic [DATA_W-1:0]          extData,
  output logic [DATA_W-1:0]          busOut,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  logic [DATA_W-1:0] regQ   [NUM_REGS];
  logic [DATA_W-1:0] srcVal [SRC_CNT];
  logic [DATA_W-1:0] busVal;

  // Source list: registers first, external word last
  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_src
      assign srcVal[k] = regQ[k];
    end
  endgenerate
  assign srcVal[EXT_IDX] = extData;

  // Shared bus as AND-OR of gated sources (stands in for tri-state node)
  always_comb begin
    busVal = '0;
    for (int k = 0; k < SRC_CNT; k++) begin
      busVal = busVal | (srcVal[k] & {DATA_W{strobe.drive[k]}});
    end
  end
  assign busOut = busVal;

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(strobe.drive)); // R3

  AST_BUS_FROM_EXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drive[EXT_IDX] |-> busOut == extData); // R2

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 regQ[i] <= '0;
        else if (strobe.capture[i]) regQ[i] <= busVal;
      end
      assign regFlat[i*DATA_W +: DATA_W] = regQ[i];

      AST_BUS_FROM_REG: assert property (@(posedge clk) disable iff (!rstN)
        strobe.drive[i] |-> busOut == regQ[i]); // R1

      AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture[i] |=> regQ[i] == $past(busOut)); // R3

      AST_HOLD_UNLOADED: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture[i] |=> $stable(regQ[i])); // R4

      AST_SELF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture[i] && strobe.drive[i]) |=> $stable(regQ[i])); // R5
    end
  endgenerate
endmodule

// File: rtl/bus_xfer_unit.sv
module bus_xfer_unit
  import bus_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEL_W-1:0]           srcSel,
  input  logic [NUM_REGS-1:0]        loadEn,
  input  logic [DATA_W-1:0]          extData,
  output logic [DATA_W-1:0]          busOut,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  xfer_strobe_t strobe;

  bus_xfer_ctrl u_ctrl (
    .srcSel (srcSel),
    .loadEn (loadEn),
    .strobe (strobe)
  );

  bus_xfer_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .extData (extData),
    .busOut  (busOut),
    .regFlat (regFlat)
  );
endmodule

// File: tb/sim_bus_xfer_unit.sv
`timescale 1ns/1ps
module sim_bus_xfer_unit;
  localparam int DW = 8;
  localparam int NR = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      srcSel = '0;
  logic [NR-1:0]   loadEn = '0;
  logic [DW-1:0]   extData = '0;
  logic [DW-1:0]   busOut;
  logic [NR*DW-1:0] regFlat;

  int nVec = 0;
  int nBad = 0;
  logic [DW-1:0] model [NR];

  always #2 clk = ~clk; // 250 MHz

  bus_xfer_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .loadEn(loadEn),
    .extData(extData), .busOut(busOut), .regFlat(regFlat)
  );

  function automatic logic [DW-1:0] regAt(int k);
    return regFlat[k*DW +: DW];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one transfer between edges, check bus, then registers after edge
  task automatic xfer(logic [1:0] sel, logic [NR-1:0] ld, logic [DW-1:0] ext);
    logic [DW-1:0] busExp;
    @(negedge clk);
    srcSel = sel; loadEn = ld; extData = ext;
    #1;
    busExp = (sel == 2'd3) ? ext : model[sel];
    check(sel == 2'd3 ? "R2" : "R1", busOut, busExp);
    for (int i = 0; i < NR; i++) if (ld[i]) model[i] = busExp;
    @(posedge clk); #1;
    for (int i = 0; i < NR; i++) begin
      if (ld[i] && int'(sel) == i) check("R5", regAt(i), model[i]);
      else if (ld[i])              check("R3 R8", regAt(i), model[i]);
      else                         check("R4", regAt(i), model[i]);
    end
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    #9;
    for (int i = 0; i < NR; i++) check("R6", regAt(i), 8'h00);
    @(negedge clk); rstN = 1'b1;

    // Distinct seeds via the external input
    xfer(2'd3, 3'b001, 8'h11);
    xfer(2'd3, 3'b010, 8'h22);
    xfer(2'd3, 3'b100, 8'h44);

    // Sweep every source code against every load pattern
    for (int r = 0; r < 3; r++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 8; l++)
          xfer(2'(s), 3'(l), 8'((r * 37 + s * 11 + l * 5 + 1) & 8'hFF));

    // R7: swap R0 and R1 through R2
    xfer(2'd3, 3'b001, 8'hA5);
    xfer(2'd3, 3'b010, 8'h3C);
    xfer(2'd0, 3'b100, 8'h00);
    xfer(2'd1, 3'b001, 8'h00);
    xfer(2'd2, 3'b010, 8'h00);
    check("R7", regAt(0), 8'h3C);
    check("R7", regAt(1), 8'hA5);

    // R6: asynchronous reset between edges
    @(negedge clk); loadEn = '0; #0.5;
    rstN = 1'b0; #0.5;
    for (int i = 0; i < NR; i++) check("R6", regAt(i), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule